// File: doc/BRIEF.md
# T1 Robbed-Bit Signaling Engine

This block carries channel-associated signaling inside the least significant bit (bit 8 in telephony numbering) of each of the 24 DS0 channels of a T1 frame. Bytes move through it one at a time. Each byte arrives with its frame number within the multiframe and its channel number, and is tagged by a valid strobe. The surrounding framer supplies that position. The multiframe is 12 frames long in D4 mode and 24 frames long in ESF mode. Only frames 6, 12, 18 and 24 carry signaling, so only those frames are touched.

On the transmit side, the engine overwrites bit 8 of each channel in a signaling frame with one bit of the per-channel nibble presented on `txSigNib`. On the receive side, it gathers the robbed bits of each channel over a multiframe and commits the finished nibble to a 24-entry store. A combinational read port reads that store. While the framer reports reframing, the store and all partial captures hold still. An optional debounce delays a change in the stored nibble until the new value has repeated long enough to cover 48 frames, which is 6 ms at 125 µs per frame.

The byte indices used below are zero-based: frame index 5 is the 6th frame and frame index 23 is the 24th. Bit 8 of a DS0 byte is bit 0 of the 8-bit port. The bit letters A, B, C and D map to bits 3, 2, 1 and 0 of every nibble.

Top module: `rbsEngine`

## Requirements
- R1: Every transmit byte with `byteValid` high appears on `txByteOut` one clock later with `txValidOut` high. In a signaling frame, bit 0 is replaced by the selected signaling bit and bits 7:1 are unchanged.
- R2: The signaling frames and letters are: frame index 5 carries A (`txSigNib[3]`), 11 carries B (`[2]`), 17 carries C (`[1]`) and 23 carries D (`[0]`). In D4 mode (`esfMode` low), only indices 5 and 11 are signaling frames, and every index of 12 or above is treated as a non-signaling frame.
- R3: While `insertDisable` is high, transmit bytes pass unchanged, including in signaling frames.
- R4: In non-signaling frames, the transmit byte passes unchanged. The receive byte always appears unchanged on `rxByteOut` one clock later with `rxValidOut` high.
- R5: The receive nibble of a channel is written only by the byte at the last signaling frame of the multiframe (index 23 in ESF, 11 in D4), and it becomes visible on `rdNib` after that clock. The earlier signaling frames leave the stored value unchanged. In ESF, the written nibble is {A,B,C,D}, built from bit 0 of the bytes at indices 5, 11, 17 and 23.
- R6: In D4 mode, `rdNib` returns {A, B, `spareBits[1]`, `spareBits[0]`}. The spare value is applied at read time.
- R7: While `reframing` is high, neither the store nor any partially captured bit changes. Bits captured before reframing began are kept and are used by the next commit after reframing ends.
- R8: With `debounceEn` high, a channel's stored nibble is written only once the same candidate nibble has been committed on that many consecutive multiframes of the channel: 2 in ESF, 4 in D4. A different candidate restarts the count at one.
- R9: After reset, the store reads zero and both valid outputs are low. A `rdChan` of 24 or above reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| esfMode | input | 1 | 1 = 24-frame ESF multiframe, 0 = 12-frame D4 |
| insertDisable | input | 1 | 1 = no transmit bit robbing |
| debounceEn | input | 1 | Enables the receive debounce |
| reframing | input | 1 | Framer is searching; freezes receive signaling |
| spareBits | input | 2 | Fill for the two low nibble bits in D4 reads |
| byteValid | input | 1 | Strobe for one channel byte |
| frameIdx | input | 5 | Frame index within the multiframe, 0-based |
| chanIdx | input | 5 | DS0 channel index, 0..23 |
| txByteIn | input | 8 | Transmit channel byte |
| txSigNib | input | 4 | Transmit signaling nibble {A,B,C,D} for chanIdx |
| rxByteIn | input | 8 | Receive channel byte |
| txByteOut | output | 8 | Transmit byte after insertion |
| txValidOut | output | 1 | txByteOut valid |
| rxByteOut | output | 8 | Receive byte, unchanged |
| rxValidOut | output | 1 | rxByteOut valid |
| rdChan | input | 5 | Channel to read from the receive store |
| rdNib | output | 4 | Receive signaling nibble for rdChan |

## Verification
Transmit insertion and receive capture act on the same byte strobe. A byte at frame index 23 both loses its transmit bit 0 to the D bit and completes the receive nibble of its channel. The bench drives one such byte and checks the rewritten transmit byte and the newly readable nibble, both taken from that single clock. The freeze can also coincide with a commit. `reframing` is raised exactly on the closing byte of a multiframe whose first three bits were already captured. The bench checks that the store keeps its old value, and that a lone closing byte after reframing ends commits a nibble that still holds those three earlier bits.

// File: rtl/rbsPkg.sv
package rbsPkg;
  localparam int CHAN_W  = 5;
  localparam int FRAME_W = 5;

  typedef struct packed {
    logic              valid;
    logic              txInsert;
    logic              capture;
    logic              commit;
    logic              freeze;
    logic [1:0]        letter;
    logic [CHAN_W-1:0] chan;
  } rbsStrobe_t;
endpackage

// File: rtl/rbsCtrl.sv
module rbsCtrl
  import rbsPkg::*;
#(
  parameter int NUM_CH = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               byteValid,
  input  logic [FRAME_W-1:0] frameIdx,
  input  logic [CHAN_W-1:0]  chanIdx,
  input  logic               esfMode,
  input  logic               insertDisable,
  input  logic               reframing,
  output rbsStrobe_t         strb
);
  localparam logic [CHAN_W-1:0]  CH_LAST   = CHAN_W'(NUM_CH - 1);
  localparam logic [FRAME_W-1:0] SIG_A_IDX = FRAME_W'(5);
  localparam logic [FRAME_W-1:0] SIG_B_IDX = FRAME_W'(11);
  localparam logic [FRAME_W-1:0] SIG_C_IDX = FRAME_W'(17);
  localparam logic [FRAME_W-1:0] SIG_D_IDX = FRAME_W'(23);

  logic       sigFrame;
  logic       lastFrame;
  logic [1:0] letter;
  logic       chanOk;

  always_comb begin
    sigFrame = 1'b0;
    letter   = 2'd0;
    unique case (frameIdx)
      SIG_A_IDX: begin sigFrame = 1'b1;    letter = 2'd0; end
      SIG_B_IDX: begin sigFrame = 1'b1;    letter = 2'd1; end
      SIG_C_IDX: begin sigFrame = esfMode; letter = 2'd2; end
      SIG_D_IDX: begin sigFrame = esfMode; letter = 2'd3; end
      default:   begin sigFrame = 1'b0;    letter = 2'd0; end
    endcase
    lastFrame = esfMode ? (frameIdx == SIG_D_IDX) : (frameIdx == SIG_B_IDX);
    chanOk    = (chanIdx <= CH_LAST);
  end

  always_comb begin
    strb.valid    = byteValid;
    strb.txInsert = byteValid && sigFrame && !insertDisable;
    strb.capture  = byteValid && sigFrame && chanOk && !reframing;
    strb.commit   = byteValid && sigFrame && chanOk && !reframing && lastFrame;
    strb.freeze   = reframing;
    strb.letter   = letter;
    strb.chan     = chanIdx;
  end

  // R2: a commit only closes the multiframe on the mode's final letter
  assert_commit_letter_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (strb.letter == (esfMode ? 2'd3 : 2'd1)));

  // R7: nothing is captured while the framer hunts
  assert_no_capture_in_reframe_R7: assert property (@(posedge clk) disable iff (!rstN)
    reframing |-> !strb.capture);
endmodule

// File: rtl/rbsDatapath.sv
module rbsDatapath
  import rbsPkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int D4_MF  = 4,
  parameter int ESF_MF = 2,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  rbsStrobe_t        strb,
  input  logic              esfMode,
  input  logic              debounceEn,
  input  logic [1:0]        spareBits,
  input  logic [7:0]        txByteIn,
  input  logic [3:0]        txSigNib,
  input  logic [7:0]        rxByteIn,
  input  logic [CHAN_W-1:0] rdChan,
  output logic [7:0]        txByteOut,
  output logic              txValidOut,
  output logic [7:0]        rxByteOut,
  output logic              rxValidOut,
  output logic [3:0]        rdNib
);
  localparam logic [CHAN_W-1:0] CH_LAST  = CHAN_W'(NUM_CH - 1);
  localparam logic [CNT_W-1:0]  NEED_D4  = CNT_W'(D4_MF);
  localparam logic [CNT_W-1:0]  NEED_ESF = CNT_W'(ESF_MF);
  localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};

  logic [NUM_CH-1:0][2:0]       stageQ;
  logic [NUM_CH-1:0][3:0]       storeQ;
  logic [NUM_CH-1:0][3:0]       prevQ;
  logic [NUM_CH-1:0][CNT_W-1:0] cntQ;

  logic             txBit;
  logic             rxBit;
  logic [2:0]       curStage;
  logic [3:0]       cand;
  logic [CNT_W-1:0] curCnt;
  logic [CNT_W-1:0] nextCnt;
  logic [CNT_W-1:0] need;
  logic             writeStore;

  // Transmit bit selection: A is the nibble MSB
  always_comb begin
    unique case (strb.letter)
      2'd0:    txBit = txSigNib[3];
      2'd1:    txBit = txSigNib[2];
      2'd2:    txBit = txSigNib[1];
      default: txBit = txSigNib[0];
    endcase
  end

  // Receive candidate assembly and debounce decision
  always_comb begin
    rxBit    = rxByteIn[0];
    curStage = stageQ[strb.chan];
    curCnt   = cntQ[strb.chan];
    cand     = esfMode ? {curStage, rxBit} : {curStage[2], rxBit, 2'b00};
    if (cand == prevQ[strb.chan])
      nextCnt = (curCnt == CNT_MAX) ? curCnt : curCnt + CNT_W'(1);
    else
      nextCnt = CNT_W'(1);
    need       = esfMode ? NEED_ESF : NEED_D4;
    writeStore = strb.commit && (!debounceEn || (nextCnt >= need));
  end

  // Byte path registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txByteOut  <= '0;
      txValidOut <= 1'b0;
      rxByteOut  <= '0;
      rxValidOut <= 1'b0;
    end else begin
      txValidOut <= strb.valid;
      rxValidOut <= strb.valid;
      if (strb.valid) begin
        txByteOut <= strb.txInsert ? {txByteIn[7:1], txBit} : txByteIn;
        rxByteOut <= rxByteIn;
      end
    end
  end

  // Per-channel staging, debounce and store
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= '0;
      storeQ <= '0;
      prevQ  <= '0;
      cntQ   <= '0;
    end else if (strb.capture) begin
      if (strb.commit) begin
        prevQ[strb.chan] <= cand;
        cntQ[strb.chan]  <= nextCnt;
        if (writeStore) storeQ[strb.chan] <= cand;
      end else begin
        stageQ[strb.chan][2 - strb.letter] <= rxBit;
      end
    end
  end

  // Read port
  always_comb begin
    if (rdChan <= CH_LAST)
      rdNib = esfMode ? storeQ[rdChan] : {storeQ[rdChan][3:2], spareBits};
    else
      rdNib = 4'd0;
  end

  // R1: upper seven bits always travel intact with one cycle of latency
  assert_tx_upper_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.valid) |-> (txValidOut && txByteOut[7:1] == $past(txByteIn[7:1])));

  // R4: non-signaling transmit bytes and all receive bytes pass unchanged
  assert_tx_pass_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.valid && !strb.txInsert) |-> (txByteOut == $past(txByteIn)));
  assert_rx_pass_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.valid) |-> (rxValidOut && rxByteOut == $past(rxByteIn)));

  // R5: the store moves only on a multiframe-closing byte
  assert_store_on_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.commit) |-> $stable(storeQ));

  // R7: store and staging are frozen while reframing
  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.freeze) |-> ($stable(storeQ) && $stable(stageQ)));
endmodule

// File: rtl/rbsEngine.sv
module rbsEngine
  import rbsPkg::*;
#(
  parameter int NUM_CH          = 24,
  parameter int DEBOUNCE_FRAMES = 48,
  parameter int D4_FRAMES       = 12,
  parameter int ESF_FRAMES      = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        esfMode,
  input  logic        insertDisable,
  input  logic        debounceEn,
  input  logic        reframing,
  input  logic [1:0]  spareBits,
  input  logic        byteValid,
  input  logic [4:0]  frameIdx,
  input  logic [4:0]  chanIdx,
  input  logic [7:0]  txByteIn,
  input  logic [3:0]  txSigNib,
  input  logic [7:0]  rxByteIn,
  output logic [7:0]  txByteOut,
  output logic        txValidOut,
  output logic [7:0]  rxByteOut,
  output logic        rxValidOut,
  input  logic [4:0]  rdChan,
  output logic [3:0]  rdNib
);
  localparam int D4_MF  = (DEBOUNCE_FRAMES + D4_FRAMES - 1) / D4_FRAMES;
  localparam int ESF_MF = (DEBOUNCE_FRAMES + ESF_FRAMES - 1) / ESF_FRAMES;
  localparam int MF_MAX = (D4_MF > ESF_MF) ? D4_MF : ESF_MF;
  localparam int CNT_W  = $clog2(MF_MAX + 1);

  rbsStrobe_t strb;

  rbsCtrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .byteValid     (byteValid),
    .frameIdx      (frameIdx),
    .chanIdx       (chanIdx),
    .esfMode       (esfMode),
    .insertDisable (insertDisable),
    .reframing     (reframing),
    .strb          (strb)
  );

  rbsDatapath #(
    .NUM_CH (NUM_CH),
    .D4_MF  (D4_MF),
    .ESF_MF (ESF_MF),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .esfMode    (esfMode),
    .debounceEn (debounceEn),
    .spareBits  (spareBits),
    .txByteIn   (txByteIn),
    .txSigNib   (txSigNib),
    .rxByteIn   (rxByteIn),
    .rdChan     (rdChan),
    .txByteOut  (txByteOut),
    .txValidOut (txValidOut),
    .rxByteOut  (rxByteOut),
    .rxValidOut (rxValidOut),
    .rdNib      (rdNib)
  );

  initial begin
    assert_param_chan_R9: assert (NUM_CH >= 1 && NUM_CH <= 32);
  end
endmodule

// File: tb/rbsEngine_tb.sv
module rbsEngine_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       esfMode = 1'b1;
  logic       insertDisable = 1'b0;
  logic       debounceEn = 1'b0;
  logic       reframing = 1'b0;
  logic [1:0] spareBits = 2'b00;
  logic       byteValid = 1'b0;
  logic [4:0] frameIdx = '0;
  logic [4:0] chanIdx = '0;
  logic [7:0] txByteIn = '0;
  logic [3:0] txSigNib = '0;
  logic [7:0] rxByteIn = '0;
  logic [7:0] txByteOut;
  logic       txValidOut;
  logic [7:0] rxByteOut;
  logic       rxValidOut;
  logic [4:0] rdChan = '0;
  logic [3:0] rdNib;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  rbsEngine u_dut (
    .clk(clk), .rstN(rstN), .esfMode(esfMode), .insertDisable(insertDisable),
    .debounceEn(debounceEn), .reframing(reframing), .spareBits(spareBits),
    .byteValid(byteValid), .frameIdx(frameIdx), .chanIdx(chanIdx),
    .txByteIn(txByteIn), .txSigNib(txSigNib), .rxByteIn(rxByteIn),
    .txByteOut(txByteOut), .txValidOut(txValidOut), .rxByteOut(rxByteOut),
    .rxValidOut(rxValidOut), .rdChan(rdChan), .rdNib(rdNib)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one byte from a negedge; returns at the next negedge with outputs settled
  task automatic sendByte(input logic [4:0] f, input logic [4:0] c, input logic [7:0] tx,
                          input logic [7:0] rx, input logic [3:0] nib);
    frameIdx = f; chanIdx = c; txByteIn = tx; rxByteIn = rx; txSigNib = nib;
    byteValid = 1'b1;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic readNib(input logic [4:0] c, output logic [3:0] nib);
    rdChan = c;
    #1;
    nib = rdNib;
  endtask

  // Full ESF multiframe of signaling bytes for one channel, receive nibble {a,b,c,d}
  task automatic rxMultiframeEsf(input logic [4:0] c, input logic [3:0] n);
    sendByte(5'd5,  c, 8'h00, {7'd0, n[3]}, 4'h0);
    sendByte(5'd11, c, 8'h00, {7'd0, n[2]}, 4'h0);
    sendByte(5'd17, c, 8'h00, {7'd0, n[1]}, 4'h0);
    sendByte(5'd23, c, 8'h00, {7'd0, n[0]}, 4'h0);
  endtask

  task automatic rxMultiframeD4(input logic [4:0] c, input logic [1:0] ab);
    sendByte(5'd5,  c, 8'h00, {7'd0, ab[1]}, 4'h0);
    sendByte(5'd11, c, 8'h00, {7'd0, ab[0]}, 4'h0);
  endtask

  task automatic testReset();
    logic [3:0] n;
    check("R9 txValidOut after reset", {7'd0, txValidOut}, 8'h00);
    check("R9 rxValidOut after reset", {7'd0, rxValidOut}, 8'h00);
    readNib(5'd0, n);  check("R9 store chan0 after reset", {4'd0, n}, 8'h00);
    readNib(5'd23, n); check("R9 store chan23 after reset", {4'd0, n}, 8'h00);
  endtask

  task automatic testTxEsf();
    esfMode = 1'b1;
    sendByte(5'd5,  5'd3, 8'hA6, 8'h00, 4'b1010);
    check("R1 ESF A insert frame5", txByteOut, 8'hA7);
    check("R1 txValidOut", {7'd0, txValidOut}, 8'h01);
    sendByte(5'd11, 5'd3, 8'hA7, 8'h00, 4'b1010);
    check("R2 ESF B insert frame11", txByteOut, 8'hA6);
    sendByte(5'd17, 5'd3, 8'hFE, 8'h00, 4'b1010);
    check("R2 ESF C insert frame17", txByteOut, 8'hFF);
    sendByte(5'd23, 5'd3, 8'hFF, 8'h00, 4'b1010);
    check("R2 ESF D insert frame23", txByteOut, 8'hFE);
  endtask

  task automatic testTxD4();
    esfMode = 1'b0;
    sendByte(5'd5,  5'd4, 8'h00, 8'h00, 4'b0100);
    check("R2 D4 A insert frame5", txByteOut, 8'h00);
    sendByte(5'd11, 5'd4, 8'h00, 8'h00, 4'b0100);
    check("R2 D4 B insert frame11", txByteOut, 8'h01);
    sendByte(5'd17, 5'd4, 8'h00, 8'h00, 4'b1111);
    check("R2 D4 index17 not signaling", txByteOut, 8'h00);
    esfMode = 1'b1;
  endtask

  task automatic testDisable();
    insertDisable = 1'b1;
    sendByte(5'd5, 5'd5, 8'h10, 8'h00, 4'b1111);
    check("R3 insertDisable keeps byte", txByteOut, 8'h10);
    sendByte(5'd23, 5'd5, 8'h81, 8'h00, 4'b0000);
    check("R3 insertDisable keeps byte frame23", txByteOut, 8'h81);
    insertDisable = 1'b0;
  endtask

  task automatic testPass();
    sendByte(5'd4, 5'd6, 8'h54, 8'hC3, 4'b1111);
    check("R4 tx non-signaling frame", txByteOut, 8'h54);
    check("R4 rx pass non-signaling", rxByteOut, 8'hC3);
    check("R4 rxValidOut", {7'd0, rxValidOut}, 8'h01);
    sendByte(5'd5, 5'd6, 8'h00, 8'h3C, 4'b0000);
    check("R4 rx pass signaling frame", rxByteOut, 8'h3C);
  endtask

  task automatic testRxEsf();
    logic [3:0] n;
    esfMode = 1'b1; debounceEn = 1'b0;
    sendByte(5'd5, 5'd7, 8'h00, 8'h01, 4'h0);
    readNib(5'd7, n); check("R5 no update after A", {4'd0, n}, 8'h00);
    sendByte(5'd11, 5'd7, 8'h00, 8'h00, 4'h0);
    sendByte(5'd17, 5'd7, 8'h00, 8'h01, 4'h0);
    readNib(5'd7, n); check("R5 no update after C", {4'd0, n}, 8'h00);
    sendByte(5'd23, 5'd7, 8'h00, 8'h01, 4'h0);
    readNib(5'd7, n); check("R5 ESF nibble committed", {4'd0, n}, 8'h0B);
  endtask

  task automatic testRxD4();
    logic [3:0] n;
    esfMode = 1'b0; spareBits = 2'b01;
    sendByte(5'd5, 5'd2, 8'h00, 8'h01, 4'h0);
    readNib(5'd2, n); check("R6 D4 spare fill before commit", {4'd0, n}, 8'h01);
    sendByte(5'd11, 5'd2, 8'h00, 8'h01, 4'h0);
    readNib(5'd2, n); check("R6 D4 AB plus spare", {4'd0, n}, 8'h0D);
    spareBits = 2'b10;
    readNib(5'd2, n); check("R6 spare applied at read", {4'd0, n}, 8'h0E);
    spareBits = 2'b00; esfMode = 1'b1;
  endtask

  task automatic testFreeze();
    logic [3:0] n;
    esfMode = 1'b1; debounceEn = 1'b0;
    sendByte(5'd5,  5'd14, 8'h00, 8'h01, 4'h0);
    sendByte(5'd11, 5'd14, 8'h00, 8'h01, 4'h0);
    sendByte(5'd17, 5'd14, 8'h00, 8'h01, 4'h0);
    reframing = 1'b1;
    sendByte(5'd23, 5'd14, 8'h00, 8'h01, 4'h0);
    readNib(5'd14, n); check("R7 commit blocked in reframe", {4'd0, n}, 8'h00);
    rxMultiframeEsf(5'd15, 4'b1111);
    readNib(5'd15, n); check("R7 full multiframe frozen", {4'd0, n}, 8'h00);
    reframing = 1'b0;
    sendByte(5'd23, 5'd14, 8'h00, 8'h01, 4'h0);
    readNib(5'd14, n); check("R7 staged bits kept through reframe", {4'd0, n}, 8'h0F);
  endtask

  task automatic testDebounce();
    logic [3:0] n;
    debounceEn = 1'b1; esfMode = 1'b1;
    rxMultiframeEsf(5'd9, 4'b0110);
    readNib(5'd9, n); check("R8 ESF first match held", {4'd0, n}, 8'h00);
    rxMultiframeEsf(5'd9, 4'b0110);
    readNib(5'd9, n); check("R8 ESF second match accepted", {4'd0, n}, 8'h06);
    rxMultiframeEsf(5'd9, 4'b1111);
    readNib(5'd9, n); check("R8 ESF glitch rejected", {4'd0, n}, 8'h06);
    rxMultiframeEsf(5'd9, 4'b0000);
    readNib(5'd9, n); check("R8 ESF count restarted", {4'd0, n}, 8'h06);
    esfMode = 1'b0;
    for (int i = 0; i < 3; i++) rxMultiframeD4(5'd10, 2'b11);
    readNib(5'd10, n); check("R8 D4 held after three", {4'd0, n}, 8'h00);
    rxMultiframeD4(5'd10, 2'b11);
    readNib(5'd10, n); check("R8 D4 accepted after four", {4'd0, n}, 8'h0C);
    esfMode = 1'b1; debounceEn = 1'b0;
  endtask

  task automatic testConcurrent();
    logic [3:0] n;
    esfMode = 1'b1; debounceEn = 1'b0;
    sendByte(5'd5,  5'd12, 8'h00, 8'h01, 4'b0001);
    sendByte(5'd11, 5'd12, 8'h00, 8'h00, 4'b0001);
    sendByte(5'd17, 5'd12, 8'h00, 8'h00, 4'b0001);
    sendByte(5'd23, 5'd12, 8'hA0, 8'h01, 4'b0001);
    check("R1 tx D insert with rx commit", txByteOut, 8'hA1);
    readNib(5'd12, n); check("R5 rx commit with tx insert", {4'd0, n}, 8'h09);
  endtask

  task automatic testRange();
    logic [3:0] n;
    readNib(5'd24, n); check("R9 rdChan 24 reads zero", {4'd0, n}, 8'h00);
    readNib(5'd31, n); check("R9 rdChan 31 reads zero", {4'd0, n}, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTxEsf();
    testTxD4();
    testDisable();
    testPass();
    testRxEsf();
    testRxD4();
    testFreeze();
    testDebounce();
    testConcurrent();
    testRange();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule